// File: doc/BRIEF.md
# Secure Privilege and Access Checker

This block holds the machine state word of one hardware thread. Three bits of that word, secure, hypervisor and problem, select the thread's current privilege level. One secure bit raises the top of the ladder to a fourth level, the secure firmware level. That level sits above the hypervisor. Only the secure firmware level may turn the secure bit on.

Every cycle the block decodes the level and judges each request presented to it:
- a memory access tagged secure or normal;
- a DMA access from I/O;
- a write to a protected special register;
- a return-from-interrupt that reloads the state word;
- an interrupt or hypercall that needs a destination.

Grants, the emulation-assistance fault and the interrupt route are combinational in the request cycle. Updates to the state word and to the small control register appear after the next clock edge.

The control register has two bits, enable (bit 0) and debug ownership (bit 1). With enable set, a firmware-entry event puts the thread at the secure firmware level. With debug ownership set, the breakpoint and watchpoint registers belong to that level alone.

Top module: `sec_priv_checker`

## Requirements
- R1: `priv_o` decodes the state bits S (bit 41), HV (bit 60) and PR (bit 49) as follows: 0 problem, 1 OS, 2 hypervisor, 3 host problem, 4 secure firmware, 5 reserved. With S=0 the codes are HV,PR = 0,1 → 0; 0,0 → 1; 1,0 → 2; 1,1 → 3. With S=1 the codes are 0,1 → 0; 0,0 → 1; 1,0 → 4; 1,1 → 5.
- R2: A return at any level other than secure firmware keeps the current value of the S bit, whatever the requested value. Only a secure-firmware return, or an enabled firmware entry, can set S.
- R3: A return has no effect on the state word and raises `emu_fault_o` in the same cycle in two cases: it would produce S,HV,PR = 1,1,1, or it is issued from level 0, 3 or 5.
- R4: A memory request tagged secure is granted only while S=1. A memory request tagged normal is always granted.
- R5: A DMA request tagged secure is never granted. A DMA request tagged normal is always granted.
- R6: `route_o` uses the codes 0 none, 2 hypervisor, 3 secure firmware. While S=1, any interrupt or hypercall gives 3. While S=0 it gives 2. With no event the code is 0.
- R7: A write with `spr_sel_i` set to 1 (partition-table control) or 2 (monitor base / collection registers) is granted at level 4. At any other level it is refused and raises `emu_fault_o`.
- R8: `spr_sel_i`=3 selects the debug registers. With debug ownership set, the rule of R7 applies. With it clear, the write raises no fault; it is granted while S=0 at levels 1 or 2 and refused while S=1.
- R9: `spr_sel_i`=0 writes the control register. The write is taken at level 4. At any other level it raises `emu_fault_o` and leaves `ctl_o` unchanged.
- R10: `fw_entry_i` sets S,HV,PR to 1,1,0 at the next edge when enable is set. When enable is clear, `fw_entry_i` is ignored. A firmware entry takes priority over a return in the same cycle.
- R11: Reset, which is synchronous and active high, clears the state word to normal OS state and loads `ctl_o` with 01: enable set, debug ownership clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_entry_i | input | 1 | Firmware-entry event |
| rfi_i | input | 1 | Return-from-interrupt request |
| rfi_msr_i | input | 64 | State word requested by the return |
| mem_req_i | input | 1 | Memory access request |
| mem_secure_i | input | 1 | Memory access targets secure memory |
| dma_req_i | input | 1 | DMA access request |
| dma_secure_i | input | 1 | DMA access targets secure memory |
| spr_wr_i | input | 1 | Protected register write |
| spr_sel_i | input | 2 | Register group selector |
| spr_wdata_i | input | 2 | Control register write data |
| irq_i | input | 1 | Interrupt pending |
| hcall_i | input | 1 | Hypercall issued |
| msr_o | output | 64 | Current state word |
| priv_o | output | 3 | Decoded privilege level |
| ctl_o | output | 2 | Control register {debug, enable} |
| mem_grant_o | output | 1 | Memory access granted |
| dma_grant_o | output | 1 | DMA access granted |
| spr_grant_o | output | 1 | Register write granted |
| emu_fault_o | output | 1 | Emulation-assistance fault |
| route_o | output | 2 | Interrupt destination |

## Verification
Grants, `route_o` and `emu_fault_o` are due in the cycle of the request. The bench drives each request just after a falling edge and samples these outputs 1 ns later, before the next rising edge. `msr_o`, `priv_o` and `ctl_o` change one edge after the stimulus. The bench reads them at the falling edge that follows that rising edge. A refused return or write is checked this way: the bench reads the unchanged state at that later point.

// File: rtl/secpriv_pkg.sv
package secpriv_pkg;
  typedef enum logic [2:0] {
    PL_PROB     = 3'd0,
    PL_OS       = 3'd1,
    PL_HYP      = 3'd2,
    PL_HOSTPROB = 3'd3,
    PL_ULTRA    = 3'd4,
    PL_RSVD     = 3'd5
  } priv_e;

  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_OS    = 2'd1,
    RT_HYP   = 2'd2,
    RT_ULTRA = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    SPR_CTL  = 2'd0,
    SPR_PTAB = 2'd1,
    SPR_MON  = 2'd2,
    SPR_DBG  = 2'd3
  } spr_e;

  function automatic logic is_problem(priv_e p);
    return (p == PL_PROB) || (p == PL_HOSTPROB) || (p == PL_RSVD);
  endfunction
endpackage

// File: rtl/priv_decode.sv
module priv_decode
  import secpriv_pkg::*;
(
  input  logic  s,
  input  logic  hv,
  input  logic  pr,
  output priv_e lvl
);
  always_comb begin
    unique case ({s, hv, pr})
      3'b001, 3'b101: lvl = PL_PROB;
      3'b000, 3'b100: lvl = PL_OS;
      3'b010:         lvl = PL_HYP;
      3'b011:         lvl = PL_HOSTPROB;
      3'b110:         lvl = PL_ULTRA;
      default:        lvl = PL_RSVD;
    endcase
  end
endmodule

// File: rtl/msr_update.sv
module msr_update
  import secpriv_pkg::*;
#(
  parameter int MSR_W  = 64,
  parameter int S_BIT  = 41,
  parameter int HV_BIT = 60,
  parameter int PR_BIT = 49
) (
  input  logic             clk,
  input  logic             rst,
  input  priv_e            lvl,
  input  logic             ena,
  input  logic             fw_entry,
  input  logic             rfi_req,
  input  logic [MSR_W-1:0] rfi_val,
  output logic [MSR_W-1:0] msr_q,
  output logic             rfi_fault
);
  logic [MSR_W-1:0] cand;
  logic             bad;
  logic             entry_take;

  assign entry_take = fw_entry && ena;

  always_comb begin
    cand = rfi_val;
    if (lvl != PL_ULTRA) cand[S_BIT] = msr_q[S_BIT];
    bad = is_problem(lvl) || (cand[S_BIT] && cand[HV_BIT] && cand[PR_BIT]);
  end

  assign rfi_fault = rfi_req && !entry_take && bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q <= '0;
    end else if (entry_take) begin
      msr_q[S_BIT]  <= 1'b1;
      msr_q[HV_BIT] <= 1'b1;
      msr_q[PR_BIT] <= 1'b0;
    end else if (rfi_req && !bad) begin
      msr_q <= cand;
    end
  end
endmodule

// File: rtl/access_check.sv
module access_check
  import secpriv_pkg::*;
(
  input  priv_e      lvl,
  input  logic       s,
  input  logic       dbg_own,
  input  logic       mem_req,
  input  logic       mem_sec,
  input  logic       dma_req,
  input  logic       dma_sec,
  input  logic       spr_wr,
  input  logic [1:0] spr_sel,
  input  logic       irq,
  input  logic       hcall,
  output logic       mem_grant,
  output logic       dma_grant,
  output logic       spr_grant,
  output logic       spr_fault,
  output logic [1:0] route
);
  logic ultra;
  assign ultra = (lvl == PL_ULTRA);

  assign mem_grant = mem_req && (!mem_sec || s);
  assign dma_grant = dma_req && !dma_sec;

  always_comb begin
    spr_grant = 1'b0;
    spr_fault = 1'b0;
    if (spr_wr) begin
      if (spr_e'(spr_sel) != SPR_DBG || dbg_own) begin
        spr_grant = ultra;
        spr_fault = !ultra;
      end else begin
        spr_grant = !s && !is_problem(lvl);
      end
    end
  end

  always_comb begin
    if (irq || hcall) route = s ? RT_ULTRA : RT_HYP;
    else              route = RT_NONE;
  end
endmodule

// File: rtl/sec_priv_checker.sv
module sec_priv_checker
  import secpriv_pkg::*;
#(
  parameter int         MSR_W   = 64,
  parameter int         S_BIT   = 41,
  parameter int         HV_BIT  = 60,
  parameter int         PR_BIT  = 49,
  parameter int         CTL_W   = 2,
  parameter logic [1:0] CTL_RST = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fw_entry_i,
  input  logic             rfi_i,
  input  logic [MSR_W-1:0] rfi_msr_i,
  input  logic             mem_req_i,
  input  logic             mem_secure_i,
  input  logic             dma_req_i,
  input  logic             dma_secure_i,
  input  logic             spr_wr_i,
  input  logic [1:0]       spr_sel_i,
  input  logic [CTL_W-1:0] spr_wdata_i,
  input  logic             irq_i,
  input  logic             hcall_i,
  output logic [MSR_W-1:0] msr_o,
  output logic [2:0]       priv_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             mem_grant_o,
  output logic             dma_grant_o,
  output logic             spr_grant_o,
  output logic             emu_fault_o,
  output logic [1:0]       route_o
);
  localparam int EN_IDX  = 0;
  localparam int DBG_IDX = 1;

  priv_e            lvl;
  logic [MSR_W-1:0] msr_q;
  logic [CTL_W-1:0] ctl_q;
  logic             rfi_fault;
  logic             spr_fault;

  priv_decode u_dec (
    .s  (msr_q[S_BIT]),
    .hv (msr_q[HV_BIT]),
    .pr (msr_q[PR_BIT]),
    .lvl(lvl)
  );

  msr_update #(
    .MSR_W(MSR_W), .S_BIT(S_BIT), .HV_BIT(HV_BIT), .PR_BIT(PR_BIT)
  ) u_msr (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .ena      (ctl_q[EN_IDX]),
    .fw_entry (fw_entry_i),
    .rfi_req  (rfi_i),
    .rfi_val  (rfi_msr_i),
    .msr_q    (msr_q),
    .rfi_fault(rfi_fault)
  );

  access_check u_acc (
    .lvl      (lvl),
    .s        (msr_q[S_BIT]),
    .dbg_own  (ctl_q[DBG_IDX]),
    .mem_req  (mem_req_i),
    .mem_sec  (mem_secure_i),
    .dma_req  (dma_req_i),
    .dma_sec  (dma_secure_i),
    .spr_wr   (spr_wr_i),
    .spr_sel  (spr_sel_i),
    .irq      (irq_i),
    .hcall    (hcall_i),
    .mem_grant(mem_grant_o),
    .dma_grant(dma_grant_o),
    .spr_grant(spr_grant_o),
    .spr_fault(spr_fault),
    .route    (route_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_W'(CTL_RST);
    end else if (spr_wr_i && spr_e'(spr_sel_i) == SPR_CTL && lvl == PL_ULTRA) begin
      ctl_q <= spr_wdata_i;
    end
  end

  assign msr_o       = msr_q;
  assign priv_o      = lvl;
  assign ctl_o       = ctl_q;
  assign emu_fault_o = rfi_fault | spr_fault;
endmodule

// File: rtl/sec_priv_props.sv
module sec_priv_props #(
  parameter int MSR_W  = 64,
  parameter int S_BIT  = 41,
  parameter int HV_BIT = 60,
  parameter int PR_BIT = 49,
  parameter int CTL_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             fw_entry_i,
  input logic             mem_req_i,
  input logic             mem_secure_i,
  input logic             dma_req_i,
  input logic             dma_secure_i,
  input logic             spr_wr_i,
  input logic [1:0]       spr_sel_i,
  input logic             irq_i,
  input logic             hcall_i,
  input logic [MSR_W-1:0] msr_o,
  input logic [2:0]       priv_o,
  input logic [CTL_W-1:0] ctl_o,
  input logic             mem_grant_o,
  input logic             dma_grant_o,
  input logic             emu_fault_o,
  input logic [1:0]       route_o
);
  assert_secure_set_by_top_R2: assert property (@(posedge clk) disable iff (rst)
    (msr_o[S_BIT] && !$past(msr_o[S_BIT])) |->
      ($past(priv_o) == 3'd4 || ($past(fw_entry_i) && $past(ctl_o[0]))));

  assert_never_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    !(msr_o[S_BIT] && msr_o[HV_BIT] && msr_o[PR_BIT]));

  assert_secure_mem_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_i && mem_secure_i && !msr_o[S_BIT]) |-> !mem_grant_o);

  assert_dma_block_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_req_i && dma_secure_i) |-> !dma_grant_o);

  assert_route_top_R6: assert property (@(posedge clk) disable iff (rst)
    (msr_o[S_BIT] && (irq_i || hcall_i)) |-> route_o == 2'd3);

  assert_prot_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (spr_wr_i && (spr_sel_i == 2'd1 || spr_sel_i == 2'd2) && priv_o != 3'd4) |-> emu_fault_o);
endmodule

bind sec_priv_checker sec_priv_props #(
  .MSR_W(MSR_W), .S_BIT(S_BIT), .HV_BIT(HV_BIT), .PR_BIT(PR_BIT), .CTL_W(CTL_W)
) u_props (
  .clk(clk), .rst(rst), .fw_entry_i(fw_entry_i),
  .mem_req_i(mem_req_i), .mem_secure_i(mem_secure_i),
  .dma_req_i(dma_req_i), .dma_secure_i(dma_secure_i),
  .spr_wr_i(spr_wr_i), .spr_sel_i(spr_sel_i),
  .irq_i(irq_i), .hcall_i(hcall_i),
  .msr_o(msr_o), .priv_o(priv_o), .ctl_o(ctl_o),
  .mem_grant_o(mem_grant_o), .dma_grant_o(dma_grant_o),
  .emu_fault_o(emu_fault_o), .route_o(route_o)
);

// File: tb/tb_sec_priv_checker.sv
`timescale 1ns/1ps
module tb_sec_priv_checker;
  localparam int MSR_W = 64;
  localparam int SB = 41, HB = 60, PB = 49;
  localparam int NVEC = 8;
  // {s,hv,pr, msec,dsec, irq,hcall, exp_mem,exp_dma, exp_route[1:0], exp_priv[2:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {3'b000, 2'b10, 2'b10, 2'b01, 2'd2, 3'd1},
    {3'b001, 2'b01, 2'b01, 2'b10, 2'd2, 3'd0},
    {3'b010, 2'b11, 2'b10, 2'b00, 2'd2, 3'd2},
    {3'b011, 2'b00, 2'b00, 2'b11, 2'd0, 3'd3},
    {3'b100, 2'b10, 2'b10, 2'b11, 2'd3, 3'd1},
    {3'b101, 2'b11, 2'b01, 2'b10, 2'd3, 3'd0},
    {3'b110, 2'b01, 2'b11, 2'b10, 2'd3, 3'd4},
    {3'b110, 2'b10, 2'b00, 2'b11, 2'd0, 3'd4}
  };

  logic clk = 0, rst = 1;
  logic fw_entry_i = 0, rfi_i = 0;
  logic [MSR_W-1:0] rfi_msr_i = '0;
  logic mem_req_i = 0, mem_secure_i = 0, dma_req_i = 0, dma_secure_i = 0;
  logic spr_wr_i = 0;
  logic [1:0] spr_sel_i = 0, spr_wdata_i = 0;
  logic irq_i = 0, hcall_i = 0;
  logic [MSR_W-1:0] msr_o;
  logic [2:0] priv_o;
  logic [1:0] ctl_o, route_o;
  logic mem_grant_o, dma_grant_o, spr_grant_o, emu_fault_o;

  int checks = 0, failures = 0;
  logic done = 0;
  logic last_fault, last_grant;

  always #5 clk = ~clk;

  sec_priv_checker dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic enter_fw();
    @(negedge clk); fw_entry_i = 1;
    @(negedge clk); fw_entry_i = 0;
  endtask

  task automatic do_rfi(logic s, logic hv, logic pr, logic b0);
    @(negedge clk);
    rfi_msr_i = '0;
    rfi_msr_i[SB] = s; rfi_msr_i[HB] = hv; rfi_msr_i[PB] = pr; rfi_msr_i[0] = b0;
    rfi_i = 1;
    #1 last_fault = emu_fault_o;
    @(negedge clk); rfi_i = 0;
  endtask

  task automatic do_spr(logic [1:0] sel, logic [1:0] data);
    @(negedge clk);
    spr_sel_i = sel; spr_wdata_i = data; spr_wr_i = 1;
    #1 begin last_fault = emu_fault_o; last_grant = spr_grant_o; end
    @(negedge clk); spr_wr_i = 0;
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 msr", msr_o, 64'h0);
    chk("R11 priv", priv_o, 3'd1);
    chk("R11 ctl", ctl_o, 2'b01);

    // R1 R4 R5 R6 table walk
    for (int i = 0; i < NVEC; i++) begin
      enter_fw();
      do_rfi(VEC[i][13], VEC[i][12], VEC[i][11], 1'b0);
      chk("R1 priv", priv_o, VEC[i][2:0]);
      mem_req_i = 1; dma_req_i = 1;
      mem_secure_i = VEC[i][10]; dma_secure_i = VEC[i][9];
      irq_i = VEC[i][8]; hcall_i = VEC[i][7];
      #1;
      chk("R4 mem", mem_grant_o, VEC[i][6]);
      chk("R5 dma", dma_grant_o, VEC[i][5]);
      chk("R6 route", route_o, VEC[i][4:3]);
      mem_req_i = 0; dma_req_i = 0; irq_i = 0; hcall_i = 0;
    end

    // R2: hypervisor return cannot set S
    do_reset();
    do_rfi(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 hyp", priv_o, 3'd2);
    do_rfi(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 no fault", last_fault, 1'b0);
    chk("R2 S kept", msr_o[SB], 1'b0);
    chk("R2 other bit", msr_o[0], 1'b1);
    chk("R2 priv", priv_o, 3'd1);

    // R3: reserved target from top level
    enter_fw();
    chk("R10 entry", priv_o, 3'd4);
    do_rfi(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R3 rsvd fault", last_fault, 1'b1);
    chk("R3 rsvd unchanged", priv_o, 3'd4);
    // R3: return from problem level
    do_rfi(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 to prob", priv_o, 3'd0);
    do_rfi(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 prob fault", last_fault, 1'b1);
    chk("R3 prob unchanged", priv_o, 3'd0);

    // R7 protected registers
    do_reset();
    do_spr(2'd1, 2'd0);
    chk("R7 os ptab fault", last_fault, 1'b1);
    chk("R7 os ptab grant", last_grant, 1'b0);
    do_spr(2'd2, 2'd0);
    chk("R7 os mon fault", last_fault, 1'b1);
    enter_fw();
    do_spr(2'd1, 2'd0);
    chk("R7 top fault", last_fault, 1'b0);
    chk("R7 top grant", last_grant, 1'b1);

    // R9 control register
    do_reset();
    do_rfi(1'b0, 1'b1, 1'b0, 1'b0);
    do_spr(2'd0, 2'b11);
    chk("R9 hyp fault", last_fault, 1'b1);
    chk("R9 hyp unchanged", ctl_o, 2'b01);
    enter_fw();
    do_spr(2'd0, 2'b11);
    chk("R9 top write", ctl_o, 2'b11);

    // R8 debug ownership
    do_rfi(1'b1, 1'b0, 1'b0, 1'b0);
    do_spr(2'd3, 2'd0);
    chk("R8 owned fault", last_fault, 1'b1);
    chk("R8 owned grant", last_grant, 1'b0);
    enter_fw();
    do_spr(2'd0, 2'b01);
    do_rfi(1'b1, 1'b0, 1'b0, 1'b0);
    do_spr(2'd3, 2'd0);
    chk("R8 secure nofault", last_fault, 1'b0);
    chk("R8 secure grant", last_grant, 1'b0);
    enter_fw();
    do_rfi(1'b0, 1'b1, 1'b0, 1'b0);
    do_spr(2'd3, 2'd0);
    chk("R8 normal grant", last_grant, 1'b1);
    chk("R8 normal nofault", last_fault, 1'b0);

    // R10 entry ignored when enable clear
    enter_fw();
    do_spr(2'd0, 2'b00);
    chk("R10 ctl cleared", ctl_o, 2'b00);
    do_rfi(1'b0, 1'b0, 1'b0, 1'b0);
    enter_fw();
    chk("R10 ignored", priv_o, 3'd1);
    chk("R10 S clear", msr_o[SB], 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule